// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits beside a receive path and decides, for each incoming frame, whether the frame is kept or dropped. It looks only at the six-byte destination address, which reaches it one byte per cycle with a valid strobe and two framing strobes: one marks the first byte and one marks the sixth. While the bytes stream in, the block runs a CRC-32 over them. One cycle after the last byte it raises a one-cycle done pulse together with a keep/drop verdict.

The verdict depends on a small set of configuration registers, loaded through a simple write port. These hold a 48-bit station address, a 64-bit multicast hash table made of two 32-bit words, and four mode bits. The modes are, in falling priority: accept everything; accept every group address; exact station match for individual addresses with a hash lookup for group addresses; and exact station match only. Broadcast is accepted in every mode except when broadcast rejection is set and accept-everything is clear. The configuration is sampled when a frame's first byte arrives, so software may rewrite it at any time without disturbing the frame already in flight.

Top module: `rx_addr_filter`

## Requirements
- R1: In hash mode a group address (not broadcast) is accepted exactly when table bit k is set. k is bits 31:26 of the CRC-32 over the six address bytes, with polynomial 0x04C11DB7 and a preset of all ones. The bytes are fed first to last, each byte LSB first, and the result is not inverted. Bit 5 of k selects the high word (1) or the low word (0), and bits 4:0 of k select the bit within that word.
- R2: With the accept-everything bit set, every frame is accepted, including broadcast while broadcast rejection is set.
- R3: With the accept-all-group bit set, every group address is accepted whatever the table holds, and an individual address is accepted only on an exact station match. A table of all ones in hash mode gives the same verdict for group addresses.
- R4: In hash mode an individual address (bit 0 of byte 0 clear) is accepted only when all 48 bits equal the station address. An address that differs in a single bit is rejected.
- R5: With none of the accept-everything, accept-all-group and hash bits set, only an exact station match and broadcast are accepted. Every other group address is rejected, even when the table is all ones.
- R6: The all-ones address is accepted unless the broadcast-reject bit is set. When that bit is set and accept-everything is clear, the all-ones address is rejected.
- R7: filt_done is high for exactly one cycle, on the cycle after the byte that carries rx_eof. filt_accept is low whenever filt_done is low. A new frame may start on the cycle right after the last byte of the previous frame.
- R8: A register write made at or after the cycle of a frame's first byte does not change that frame's verdict. It applies from the next frame on.
- R9: rst (synchronous, active high) clears the station address, both table words and all mode bits, and clears filt_done. After reset a broadcast frame is accepted, while a group address and a non-zero individual address are rejected.
- R10: Mode priority is accept-everything, then accept-all-group, then hash, then station-only. A higher mode decides regardless of the lower bits.
- R11: The address bytes are counted in the order they are received. Byte 0 is the first byte on the wire, and its bit 0 marks a group address. Cycles with rx_valid low inside a frame are ignored.
- R12: Register map (cfg_wr_sel). 0 loads station bytes 0..3, with byte 0 in bits 7:0. 1 loads station bytes 4..5 from bits 15:0. 2 loads the low table word and 3 the high table word. 4 loads the mode: bit 0 accept-everything, bit 1 accept-all-group, bit 2 hash, bit 3 broadcast-reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select (see R12) |
| cfg_wr_data | input | 32 | Register write data |
| rx_valid | input | 1 | Address byte valid |
| rx_sof | input | 1 | Marks byte 0 of the destination address |
| rx_eof | input | 1 | Marks byte 5 of the destination address |
| rx_byte | input | 8 | Address byte |
| filt_done | output | 1 | One-cycle verdict strobe |
| filt_accept | output | 1 | Keep the frame; valid with filt_done |

## Verification
A register write takes effect at the clock edge where it is presented, and a frame picks up the configuration held at its first byte. The verdict for a frame is due exactly one edge after its sixth byte, and both outputs are zero on every other cycle. The reference model in the bench mirrors this. It records which configuration each frame captured, stages the expected done/accept pair at the edge where the last byte is driven, and compares both outputs half a cycle after every following edge, so any early, late, doubled or missing verdict shows up as a miscompare.

// File: rtl/afilt_pkg.sv
package afilt_pkg;

    localparam int unsigned ADDR_BYTES  = 6;
    localparam int unsigned ADDR_W      = 8 * ADDR_BYTES;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned HASH_IDX_W  = 6;
    localparam int unsigned HASH_BITS   = 1 << HASH_IDX_W;
    localparam int unsigned CRC_W       = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = '1;
    localparam int unsigned CNT_W       = $clog2(ADDR_BYTES + 1);

    typedef enum logic [2:0] {
        SEL_STA_LO  = 3'd0,
        SEL_STA_HI  = 3'd1,
        SEL_HASH_LO = 3'd2,
        SEL_HASH_HI = 3'd3,
        SEL_MODE    = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic bcast_rej;
        logic hash_en;
        logic all_group;
        logic take_all;
    } mode_t;

    typedef struct packed {
        logic [ADDR_W-1:0]    station;
        logic [HASH_BITS-1:0] table_bits;
        mode_t                mode;
    } cfg_t;

    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0] crc_in,
        input logic [7:0]       data
    );
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[CRC_W-1] ^ data[i])
                c = {c[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            else
                c = {c[CRC_W-2:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic verdict(
        input cfg_t              cfg,
        input logic [ADDR_W-1:0] dst,
        input logic              table_hit
    );
        logic v;
        if (cfg.mode.take_all)
            v = 1'b1;
        else if (&dst)
            v = ~cfg.mode.bcast_rej;
        else if (dst[0])
            v = cfg.mode.all_group | (cfg.mode.hash_en & table_hit);
        else
            v = (dst == cfg.station);
        return v;
    endfunction

endpackage

// File: rtl/afilt_regs.sv
module afilt_regs
    import afilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output cfg_t              cfg
);
    localparam int unsigned HI_W = ADDR_W - WORD_W;

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_STA_LO:  cfg_q.station[WORD_W-1:0]         <= wr_data;
                SEL_STA_HI:  cfg_q.station[ADDR_W-1:WORD_W]    <= wr_data[HI_W-1:0];
                SEL_HASH_LO: cfg_q.table_bits[WORD_W-1:0]      <= wr_data;
                SEL_HASH_HI: cfg_q.table_bits[2*WORD_W-1:WORD_W] <= wr_data;
                SEL_MODE:    cfg_q.mode                        <= mode_t'(wr_data[$bits(mode_t)-1:0]);
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/afilt_crc.sv
module afilt_crc
    import afilt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [7:0]       rx_byte,
    output logic [CRC_W-1:0] crc_nxt
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;

    assign crc_base = rx_sof ? CRC_INIT : crc_q;
    assign crc_nxt  = crc_step_byte(crc_base, rx_byte);

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= CRC_INIT;
        else if (rx_valid)
            crc_q <= crc_nxt;
    end
endmodule

// File: rtl/afilt_decide.sv
module afilt_decide
    import afilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_byte,
    input  cfg_t              cfg_live,
    input  logic [CRC_W-1:0]  crc_nxt,
    output cfg_t              cfg_snap,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              done,
    output logic              accept
);
    logic [CNT_W-1:0]      bcnt_q;
    logic [CNT_W-1:0]      slot;
    logic [ADDR_W-1:0]     addr_q;
    logic [ADDR_W-1:0]     addr_full;
    cfg_t                  snap_q;
    cfg_t                  cfg_eff;
    logic [HASH_IDX_W-1:0] hidx;
    logic                  hit;
    logic                  last;
    logic                  done_q;
    logic                  acc_q;

    assign slot = rx_sof ? '0 : bcnt_q;

    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
        assign addr_full[8*b +: 8] =
            (rx_valid && slot == CNT_W'(b)) ? rx_byte : addr_q[8*b +: 8];
    end

    assign cfg_eff = (rx_valid && rx_sof) ? cfg_live : snap_q;
    assign hidx    = crc_nxt[CRC_W-1 -: HASH_IDX_W];
    assign hit     = cfg_eff.table_bits[hidx];
    assign last    = rx_valid && rx_eof;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt_q <= '0;
            addr_q <= '0;
            snap_q <= '0;
            done_q <= 1'b0;
            acc_q  <= 1'b0;
        end else begin
            if (rx_valid) begin
                addr_q <= addr_full;
                bcnt_q <= (slot == CNT_W'(ADDR_BYTES)) ? slot : slot + 1'b1;
                if (rx_sof)
                    snap_q <= cfg_live;
            end
            done_q <= last;
            acc_q  <= last && verdict(cfg_eff, addr_full, hit);
        end
    end

    assign cfg_snap = snap_q;
    assign dst_addr = addr_q;
    assign done     = done_q;
    assign accept   = acc_q;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import afilt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_en,
    input  logic [2:0]  cfg_wr_sel,
    input  logic [31:0] cfg_wr_data,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_byte,
    output logic        filt_done,
    output logic        filt_accept
);
    cfg_t              cfg_live;
    cfg_t              cfg_snap;
    logic [CRC_W-1:0]  crc_nxt;
    logic [ADDR_W-1:0] dst_addr;

    afilt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .cfg     (cfg_live)
    );

    afilt_crc u_crc (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_byte  (rx_byte),
        .crc_nxt  (crc_nxt)
    );

    afilt_decide u_dec (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_eof   (rx_eof),
        .rx_byte  (rx_byte),
        .cfg_live (cfg_live),
        .crc_nxt  (crc_nxt),
        .cfg_snap (cfg_snap),
        .dst_addr (dst_addr),
        .done     (filt_done),
        .accept   (filt_accept)
    );
endmodule

// File: rtl/afilt_checker.sv
module afilt_checker
    import afilt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              rx_eof,
    input logic              filt_done,
    input logic              filt_accept,
    input cfg_t              cfg_live,
    input cfg_t              cfg_snap,
    input logic [ADDR_W-1:0] dst_addr
);
    a_r7_done_follows_eof: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_eof) |=> filt_done);

    a_r7_done_needs_eof: assert property (@(posedge clk) disable iff (rst)
        filt_done |-> $past(rx_valid && rx_eof));

    a_r7_accept_qualified: assert property (@(posedge clk) disable iff (rst)
        !filt_done |-> !filt_accept);

    a_r2_take_all: assert property (@(posedge clk) disable iff (rst)
        (filt_done && cfg_snap.mode.take_all) |-> filt_accept);

    a_r5_no_group_plain: assert property (@(posedge clk) disable iff (rst)
        (filt_done && !cfg_snap.mode.take_all && !cfg_snap.mode.all_group &&
         !cfg_snap.mode.hash_en && dst_addr[0] && !(&dst_addr)) |-> !filt_accept);

    a_r6_bcast_reject: assert property (@(posedge clk) disable iff (rst)
        (filt_done && (&dst_addr) && cfg_snap.mode.bcast_rej &&
         !cfg_snap.mode.take_all) |-> !filt_accept);

    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_live == '0 && !filt_done));
endmodule

bind rx_addr_filter afilt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_eof      (rx_eof),
    .filt_done   (filt_done),
    .filt_accept (filt_accept),
    .cfg_live    (cfg_live),
    .cfg_snap    (cfg_snap),
    .dst_addr    (dst_addr)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        filt_done, filt_accept;

    always #2.5 clk = ~clk;

    rx_addr_filter dut (.*);

    int vectors = 0;
    int errors  = 0;

    // behavioural model state
    logic [47:0] m_sta, s_sta;
    logic [63:0] m_tbl, s_tbl;
    logic [3:0]  m_mode, s_mode;
    logic [47:0] m_addr;
    int          m_cnt;
    logic        exp_done = 1'b0, exp_acc = 1'b0;
    string       exp_tag = "R9";

    // drive values for next tick
    logic        d_rst = 1'b1, d_wr = 1'b0, d_v = 1'b0, d_s = 1'b0, d_e = 1'b0;
    logic [2:0]  d_sel = '0;
    logic [31:0] d_data = '0;
    logic [7:0]  d_byte = '0;
    string       cur_tag = "R9";

    function automatic logic [31:0] ref_crc(logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            logic t = c[31] ^ a[k];
            c = c << 1;
            if (t) c = c ^ 32'h04C1_1DB7;
        end
        return c;
    endfunction

    function automatic int ref_idx(logic [47:0] a);
        logic [31:0] c = ref_crc(a);
        return int'(c[31:26]);
    endfunction

    function automatic logic ref_accept(logic [47:0] sta, logic [63:0] tbl,
                                        logic [3:0] md, logic [47:0] a);
        if (md[0]) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return !md[3];
        if (a[0]) return md[1] || (md[2] && tbl[ref_idx(a)]);
        return a == sta;
    endfunction

    task automatic tick();
        @(negedge clk);
        vectors++;
        if (filt_done !== exp_done || filt_accept !== exp_acc) begin
            errors++;
            $display("FAIL %s: done/accept = %b/%b expected %b/%b at %0t",
                     exp_tag, filt_done, filt_accept, exp_done, exp_acc, $time);
        end
        rst = d_rst; cfg_wr_en = d_wr; cfg_wr_sel = d_sel; cfg_wr_data = d_data;
        rx_valid = d_v; rx_sof = d_s; rx_eof = d_e; rx_byte = d_byte;
        // model of the edge that follows
        exp_done = 1'b0; exp_acc = 1'b0; exp_tag = cur_tag;
        if (d_rst) begin
            m_sta = '0; m_tbl = '0; m_mode = '0; m_cnt = 0;
        end else begin
            if (d_v) begin
                if (d_s) begin
                    s_sta = m_sta; s_tbl = m_tbl; s_mode = m_mode; m_cnt = 0;
                end
                if (m_cnt < 6) m_addr[8*m_cnt +: 8] = d_byte;
                m_cnt++;
                if (d_e) begin
                    exp_done = 1'b1;
                    exp_acc  = ref_accept(s_sta, s_tbl, s_mode, m_addr);
                end
            end
            if (d_wr) begin
                case (d_sel)
                    3'd0: m_sta[31:0]  = d_data;
                    3'd1: m_sta[47:32] = d_data[15:0];
                    3'd2: m_tbl[31:0]  = d_data;
                    3'd3: m_tbl[63:32] = d_data;
                    3'd4: m_mode       = d_data[3:0];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic idle(int n);
        d_wr = 1'b0; d_v = 1'b0; d_s = 1'b0; d_e = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] data);
        d_v = 1'b0; d_s = 1'b0; d_e = 1'b0;
        d_wr = 1'b1; d_sel = sel; d_data = data;
        tick();
        d_wr = 1'b0;
    endtask

    task automatic frame(logic [47:0] a, string tag, int gap_at = -1,
                         int wr_at = -1, logic [2:0] sel = 0, logic [31:0] data = 0);
        for (int i = 0; i < 6; i++) begin
            if (i == gap_at) begin
                d_v = 1'b0; d_s = 1'b0; d_e = 1'b0; d_byte = 8'hA5;
                tick();
            end
            cur_tag = tag;
            d_v = 1'b1; d_s = (i == 0); d_e = (i == 5); d_byte = a[8*i +: 8];
            d_wr = (i == wr_at); d_sel = sel; d_data = data;
            tick();
            d_wr = 1'b0;
        end
        d_v = 1'b0; d_s = 1'b0; d_e = 1'b0;
    endtask

    function automatic logic [47:0] find_mc(logic want_hi, int avoid);
        for (int x = 0; x < 256; x++) begin
            logic [47:0] a = {x[7:0], 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
            int k = ref_idx(a);
            if ((k >= 32) == want_hi && k != avoid) return a;
        end
        return 48'h0000_5E00_0001;
    endfunction

    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] STA   = 48'h5544_3322_1102; // 02:11:22:33:44:55
    localparam logic [47:0] OTHER = 48'h0A09_0807_0604;

    initial begin : main
        logic [47:0] mlo, mhi, mx;
        int k;
        cur_tag = "R9";
        idle(3);
        d_rst = 1'b0;
        idle(2);
        // R9 reset state
        frame(BCAST, "R9"); idle(1);
        frame(48'h0100_005E_0001 | 48'h1, "R9"); idle(1);
        frame(STA, "R9"); idle(1);
        // R12 station load, R5 station-only mode
        wr(3'd0, STA[31:0]);
        wr(3'd1, {16'h0, STA[47:32]});
        frame(STA, "R5"); idle(1);
        frame(OTHER, "R5"); idle(1);
        wr(3'd2, '1); wr(3'd3, '1);
        frame(find_mc(1'b0, -1), "R5"); idle(1);
        frame(BCAST, "R6");
        // R1 hash mode, one bit per word
        wr(3'd2, '0); wr(3'd3, '0); wr(3'd4, 32'h4);
        mlo = find_mc(1'b0, -1);
        k = ref_idx(mlo);
        wr(3'd2, 32'h1 << k);
        frame(mlo, "R1"); idle(1);
        mx = find_mc(1'b0, k);
        frame(mx, "R1"); idle(1);
        mhi = find_mc(1'b1, -1);
        frame(mhi, "R1");
        wr(3'd3, 32'h1 << (ref_idx(mhi) - 32));
        frame(mhi, "R1"); idle(1);
        // R4 exact unicast match in hash mode
        frame(STA, "R4");
        frame(STA ^ 48'h0100_0000_0000, "R4");
        frame(STA ^ 48'h0000_0000_0200, "R4"); idle(1);
        // R3 table all ones equals pass-all-group
        wr(3'd2, '1); wr(3'd3, '1);
        frame(mx, "R3"); idle(1);
        wr(3'd2, '0); wr(3'd3, '0); wr(3'd4, 32'h2);
        frame(mx, "R3");
        frame(OTHER, "R3");
        frame(STA, "R3"); idle(1);
        // R6 broadcast reject
        wr(3'd4, 32'hC);
        frame(BCAST, "R6"); idle(1);
        // R2 accept everything, even with broadcast reject
        wr(3'd4, 32'h9);
        frame(BCAST, "R2");
        frame(OTHER, "R2"); idle(1);
        // R10 priority
        wr(3'd4, 32'h7);
        frame(mx, "R10");
        wr(3'd4, 32'h6);
        frame(mx, "R10");
        frame(OTHER, "R10"); idle(1);
        // R8 mid-frame write applies next frame only
        wr(3'd4, 32'h4);
        frame(OTHER, "R8", -1, 2, 3'd4, 32'h1);
        frame(OTHER, "R8", -1, 0, 3'd4, 32'h4);
        frame(OTHER, "R8"); idle(1);
        // R11 gaps inside a frame, R7 back-to-back
        wr(3'd4, 32'h4);
        frame(STA, "R11", 3);
        frame(STA, "R11", 1);
        frame(OTHER, "R7");
        frame(STA, "R7");
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R7: watchdog expired, actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule